// File: doc/BRIEF.md
# Data TLB with translation micro-cache

This block translates a data virtual address into a physical address. Translations sit in a small, fully associative array that software fills and invalidates through a write port. A two-slot front cache sits in front of the array. It holds the two most recent successful translations, each tagged with the address space identifier (ASI) of the access that produced it, together with a copy of the translation control word that was in force when it was filled. When the control word still matches and a slot covers the request, the response comes from that slot.

Each request returns one response on the following clock edge. The response carries the physical address, an uncacheable attribute, a two-bit fault code and a flag that says whether the front cache served it. A hyperprivileged access that uses an implicit ASI skips translation: its address only passes through a fixed implementation mask. A side-effect page touched through a no-fault ASI raises a data access fault and latches the faulting page address and context.

Top module: `dtlb_xlate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rsp_valid`, `rsp_fault`, `rsp_pa`, `rsp_uncacheable`, `rsp_fast`, `tag_va` and `tag_ctx` are zero after that edge. The front cache starts empty, so the first translation after reset is never served fast.
- R2: A request sampled with `req_valid` high yields `rsp_valid` high for exactly the next cycle. A cycle with no request yields `rsp_valid` low and `rsp_fault` zero.
- R3: When `req_hpriv` and `req_implicit` are both high, there is no translation. `rsp_pa` is `req_va[PA_W-1:0] & PA_IMPL_MASK`, the fault code is 0 and `rsp_fast` is low.
- R4: An array entry matches when all of these hold: it is valid, its context equals control bits 47:32, its partition equals control bits 15:8, and the address bits above the page offset are equal. The page-size code c selects an offset of 13+3c bits. The lowest matching index wins. `rsp_pa` takes the entry's physical page above the offset and the request address inside it.
- R5: When no entry matches, the response has fault code 1 (miss), and `rsp_pa` and `rsp_uncacheable` are zero. The front cache is left unchanged, so a later request that hits it is still served fast. Every faulting response has zero `rsp_pa` and a low `rsp_uncacheable`.
- R6: A match on a side-effect entry with ASI 0x82, 0x83, 0x8A or 0x8B gives fault code 2. It also loads `tag_va` with the request address with bits 12:0 cleared, and `tag_ctx` with control bits 47:32. The front cache is not filled.
- R7: A translation from a side-effect entry that does not fault raises `rsp_uncacheable`, on both the array path and the front-cache path.
- R8: A write access that matches a non-writable array entry gives fault code 3, and the front cache is not filled.
- R9: The front cache is used only when it is valid and the stored control word equals `req_ctl`. A slot hits when all of these hold: its ASI equals `req_asi`; its page start is below `req_va + req_size`; its page end is above `req_va`; and, for a write, its page is writable. Slot 0 is checked first. A hit sets `rsp_fast` and leaves the front cache unchanged.
- R10: An array translation that does not fault writes the new page into slot 0 and moves the old slot 0 into slot 1. It also records `req_ctl`. If the front cache was invalid, both slots are emptied before this refill, so slot 1 ends up empty.
- R11: A cycle with `wr_en` or `inv_en` high marks the front cache invalid at that edge, and this wins over a refill in the same cycle. After `inv_en`, the entry at `inv_idx` no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 44 | Virtual address |
| req_size | input | 4 | Access size in bytes (1 to 8) |
| req_write | input | 1 | Access is a store |
| req_asi | input | 8 | Address space identifier |
| req_hpriv | input | 1 | Access is hyperprivileged |
| req_implicit | input | 1 | ASI is the implicit one |
| req_ctl | input | 64 | Translation control word |
| wr_en | input | 1 | Write an array entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_va | input | 44 | Page virtual address |
| wr_pgsz | input | 2 | Page-size code c (offset 13+3c bits) |
| wr_pa | input | 40 | Page physical address |
| wr_ctx | input | 16 | Entry context |
| wr_part | input | 8 | Entry partition |
| wr_writable | input | 1 | Page allows stores |
| wr_side_eff | input | 1 | Page has side effects |
| inv_en | input | 1 | Invalidate an entry |
| inv_idx | input | IDX_W | Entry index to invalidate |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 40 | Physical address |
| rsp_uncacheable | output | 1 | Access must bypass caches |
| rsp_fault | output | 2 | 0 none, 1 miss, 2 data access, 3 protection |
| rsp_fast | output | 1 | Response served by the front cache |
| tag_va | output | 44 | Page address latched on a data access fault |
| tag_ctx | output | 16 | Context latched on a data access fault |

## Verification
A stale front cache, left valid after a write or an invalidation, shows up on the very next response to the same page. That response has `rsp_fast` high, and it may also carry an address that no longer matches the array contents. A refill in the wrong order, or a slot 1 that is not emptied on a cold refill, shows up within two or three requests: a repeat of an older page comes back slow when it should be fast, or the reverse. Lost valid bits or a wrong priority among overlapping pages show up as a wrong fault code or a wrong `rsp_pa` on the first request that touches those pages.

// File: rtl/dtlb_pkg.sv
// Shared widths, control-word field positions, types and helpers for the data TLB.
package dtlb_pkg;
    localparam int VA_W       = 44;
    localparam int PA_W       = 40;
    localparam int ASI_W      = 8;
    localparam int CTX_W      = 16;
    localparam int PART_W     = 8;
    localparam int SZ_W       = 4;
    localparam int CTL_W      = 64;
    localparam int CTX_LSB    = 32;
    localparam int PART_LSB   = 8;
    localparam int BASE_SHIFT = 13;
    localparam int SHIFT_STEP = 3;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_MISS = 2'd1,
        FLT_DAE  = 2'd2,
        FLT_PROT = 2'd3
    } fault_e;

    typedef struct packed {
        logic [VA_W-1:0] va;
        logic [1:0]      pgsz;
        logic [PA_W-1:0] pa;
        logic            writable;
        logic            side_eff;
    } page_t;

    // Low-offset mask of a page with the given size code.
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] code);
        return (VA_W'(1) << (BASE_SHIFT + SHIFT_STEP * int'(code))) - VA_W'(1);
    endfunction

    // ASIs that must never touch side-effect pages.
    function automatic logic asi_no_fault(input logic [ASI_W-1:0] asi);
        return (asi[7:1] == 7'h41) || (asi[7:1] == 7'h45);
    endfunction

    // Physical page bits from the entry, offset bits from the request.
    function automatic logic [PA_W-1:0] compose_pa(input page_t p, input logic [VA_W-1:0] va);
        logic [VA_W-1:0] m;
        m = page_mask(p.pgsz);
        return (p.pa & ~m[PA_W-1:0]) | (va[PA_W-1:0] & m[PA_W-1:0]);
    endfunction
endpackage

// File: rtl/dtlb_entry_array.sv
// Fully associative translation store.
// Assumes entry pages are aligned to their size. When several entries match,
// the lowest index wins. Writes and invalidations take effect at the clock edge.
module dtlb_entry_array
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  page_t             wr_page,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [PART_W-1:0] wr_part,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    input  logic [VA_W-1:0]   look_va,
    input  logic [CTX_W-1:0]  look_ctx,
    input  logic [PART_W-1:0] look_part,
    output logic              hit,
    output page_t             hit_page
);
    if (ENTRIES > 64) begin : g_cfg_too_big
        $error("dtlb_entry_array: at most 64 entries are supported");
    end

    page_t              pg_q   [ENTRIES];
    logic [CTX_W-1:0]   ctx_q  [ENTRIES];
    logic [PART_W-1:0]  part_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] match;

    // Valid bits: a write sets one, an invalidate clears one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (inv_en) vld_q[inv_idx] <= 1'b0;
            if (wr_en)  vld_q[wr_idx]  <= 1'b1;
        end
    end

    // Entry payload storage, written on wr_en.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            pg_q[wr_idx]   <= wr_page;
            ctx_q[wr_idx]  <= wr_ctx;
            part_q[wr_idx] <= wr_part;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VA_W-1:0] off_m;
        // Per-entry tag compare over context, partition and page bits.
        always_comb begin
            off_m    = page_mask(pg_q[g].pgsz);
            match[g] = vld_q[g] && (ctx_q[g] == look_ctx) && (part_q[g] == look_part)
                       && (((pg_q[g].va ^ look_va) & ~off_m) == '0);
        end
    end

    // Priority select of the lowest matching index.
    always_comb begin
        hit      = 1'b0;
        hit_page = pg_q[0];
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_page = pg_q[i];
            end
        end
    end
endmodule

// File: rtl/dtlb_front_cache.sv
// Two-slot cache of recent translations, tagged by ASI and guarded by a stored
// copy of the control word. Assumes flush has priority over fill. A refill
// pushes slot 0 into slot 1; a refill while invalid leaves slot 1 empty.
module dtlb_front_cache
    import dtlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill,
    input  page_t            fill_page,
    input  logic [ASI_W-1:0] fill_asi,
    input  logic [CTL_W-1:0] cur_ctl,
    input  logic [VA_W-1:0]  look_va,
    input  logic [SZ_W-1:0]  look_size,
    input  logic             look_write,
    input  logic [ASI_W-1:0] look_asi,
    output logic             hit,
    output page_t            hit_page,
    output logic             valid_o
);
    localparam int SLOTS = 2;

    page_t              slot_q [SLOTS];
    logic [ASI_W-1:0]   asi_q  [SLOTS];
    logic [SLOTS-1:0]   used_q;
    logic [SLOTS-1:0]   slot_hit;
    logic               valid_q;
    logic [CTL_W-1:0]   ctl_q;
    logic               ctl_ok;

    // Validity, slot occupancy and stored control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            used_q  <= '0;
            ctl_q   <= '0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (fill) begin
            valid_q <= 1'b1;
            ctl_q   <= cur_ctl;
            used_q  <= {valid_q ? used_q[0] : 1'b0, 1'b1};
        end
    end

    // Slot payload shift on refill.
    always_ff @(posedge clk) begin
        if (fill && !flush) begin
            slot_q[1] <= slot_q[0];
            asi_q[1]  <= asi_q[0];
            slot_q[0] <= fill_page;
            asi_q[0]  <= fill_asi;
        end
    end

    assign ctl_ok  = valid_q && (ctl_q == cur_ctl);
    assign valid_o = valid_q;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [VA_W-1:0] m;
        logic [VA_W-1:0] start;
        logic [VA_W:0]   pg_end;
        logic [VA_W:0]   rq_end;
        // Range overlap, ASI and write-permission test for one slot.
        always_comb begin
            m           = page_mask(slot_q[s].pgsz);
            start       = slot_q[s].va & ~m;
            pg_end      = {1'b0, start} + {1'b0, m} + (VA_W + 1)'(1);
            rq_end      = {1'b0, look_va} + (VA_W + 1)'(look_size);
            slot_hit[s] = ctl_ok && used_q[s] && (asi_q[s] == look_asi)
                          && ({1'b0, start} < rq_end) && (pg_end > {1'b0, look_va})
                          && (!look_write || slot_q[s].writable);
        end
    end

    // Slot 0 takes precedence.
    always_comb begin
        hit      = |slot_hit;
        hit_page = slot_hit[0] ? slot_q[0] : slot_q[1];
    end
endmodule

// File: rtl/dtlb_xlate.sv
// Data TLB top. Chooses among the bypass, the front cache and the array,
// applies the fault and attribute rules and registers the response one cycle
// after the request. Assumes req_size is between 1 and 8.
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int              ENTRIES      = 16,
    parameter logic [PA_W-1:0] PA_IMPL_MASK = 40'h0F_FFFF_FFFF,
    localparam int             IDX_W        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [SZ_W-1:0]   req_size,
    input  logic              req_write,
    input  logic [ASI_W-1:0]  req_asi,
    input  logic              req_hpriv,
    input  logic              req_implicit,
    input  logic [CTL_W-1:0]  req_ctl,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_va,
    input  logic [1:0]        wr_pgsz,
    input  logic [PA_W-1:0]   wr_pa,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [PART_W-1:0] wr_part,
    input  logic              wr_writable,
    input  logic              wr_side_eff,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_uncacheable,
    output logic [1:0]        rsp_fault,
    output logic              rsp_fast,
    output logic [VA_W-1:0]   tag_va,
    output logic [CTX_W-1:0]  tag_ctx
);
    page_t           wr_page;
    logic            arr_hit, fc_hit, fc_valid;
    page_t           arr_page, fc_page;
    logic            bypass, arr_dae, arr_prot, fc_fill, tag_load;
    logic [PA_W-1:0] nxt_pa;
    logic            nxt_unc, nxt_fast;
    fault_e          nxt_fault;

    assign wr_page = '{va: wr_va, pgsz: wr_pgsz, pa: wr_pa,
                       writable: wr_writable, side_eff: wr_side_eff};

    dtlb_entry_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_page  (wr_page),
        .wr_ctx   (wr_ctx),
        .wr_part  (wr_part),
        .inv_en   (inv_en),
        .inv_idx  (inv_idx),
        .look_va  (req_va),
        .look_ctx (req_ctl[CTX_LSB +: CTX_W]),
        .look_part(req_ctl[PART_LSB +: PART_W]),
        .hit      (arr_hit),
        .hit_page (arr_page)
    );

    dtlb_front_cache u_fc (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (wr_en || inv_en),
        .fill      (fc_fill),
        .fill_page (arr_page),
        .fill_asi  (req_asi),
        .cur_ctl   (req_ctl),
        .look_va   (req_va),
        .look_size (req_size),
        .look_write(req_write),
        .look_asi  (req_asi),
        .hit       (fc_hit),
        .hit_page  (fc_page),
        .valid_o   (fc_valid)
    );

    // Path selection and fault rules for the current request.
    always_comb begin
        bypass    = req_hpriv && req_implicit;
        arr_dae   = arr_page.side_eff && asi_no_fault(req_asi);
        arr_prot  = req_write && !arr_page.writable;
        fc_fill   = req_valid && !bypass && !fc_hit && arr_hit && !arr_dae && !arr_prot;
        tag_load  = req_valid && !bypass && !fc_hit && arr_hit && arr_dae;
        nxt_pa    = '0;
        nxt_unc   = 1'b0;
        nxt_fast  = 1'b0;
        nxt_fault = FLT_NONE;
        if (req_valid) begin
            if (bypass) begin
                nxt_pa = req_va[PA_W-1:0] & PA_IMPL_MASK;
            end else if (fc_hit) begin
                nxt_pa   = compose_pa(fc_page, req_va);
                nxt_unc  = fc_page.side_eff;
                nxt_fast = 1'b1;
            end else if (!arr_hit) begin
                nxt_fault = FLT_MISS;
            end else if (arr_dae) begin
                nxt_fault = FLT_DAE;
            end else if (arr_prot) begin
                nxt_fault = FLT_PROT;
            end else begin
                nxt_pa  = compose_pa(arr_page, req_va);
                nxt_unc = arr_page.side_eff;
            end
        end
    end

    // Registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_pa          <= '0;
            rsp_uncacheable <= 1'b0;
            rsp_fault       <= FLT_NONE;
            rsp_fast        <= 1'b0;
        end else begin
            rsp_valid       <= req_valid;
            rsp_pa          <= nxt_pa;
            rsp_uncacheable <= nxt_unc;
            rsp_fault       <= nxt_fault;
            rsp_fast        <= nxt_fast;
        end
    end

    // Tag-access capture on a data access fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_va  <= '0;
            tag_ctx <= '0;
        end else if (tag_load) begin
            tag_va  <= req_va & ~VA_W'(13'h1FFF);
            tag_ctx <= req_ctl[CTX_LSB +: CTX_W];
        end
    end
endmodule

// File: rtl/dtlb_xlate_chk.sv
// Temporal checks on the data TLB ports and on the front-cache valid flag.
module dtlb_xlate_chk
    import dtlb_pkg::*;
#(
    parameter logic [PA_W-1:0] PA_IMPL_MASK = 40'h0F_FFFF_FFFF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            req_hpriv,
    input logic            req_implicit,
    input logic            wr_en,
    input logic            inv_en,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_uncacheable,
    input logic [1:0]      rsp_fault,
    input logic            rsp_fast,
    input logic [VA_W-1:0] tag_va,
    input logic            fc_valid
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_fault == 2'd0) && !rsp_fast);
    // R3
    bypass_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hpriv && req_implicit) |=>
            (rsp_fault == 2'd0) && !rsp_fast && (rsp_pa == ($past(req_va[PA_W-1:0]) & PA_IMPL_MASK)));
    // R5
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != 2'd0) |-> (rsp_pa == '0) && !rsp_uncacheable);
    // R6
    dae_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault == 2'd2) |-> (tag_va == ($past(req_va) & ~VA_W'(13'h1FFF))));
    // R9
    fast_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fast |-> (rsp_fault == 2'd0));
    // R11
    flush_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || inv_en) |=> !fc_valid);
endmodule

bind dtlb_xlate dtlb_xlate_chk #(.PA_IMPL_MASK(PA_IMPL_MASK)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_va         (req_va),
    .req_hpriv      (req_hpriv),
    .req_implicit   (req_implicit),
    .wr_en          (wr_en),
    .inv_en         (inv_en),
    .rsp_valid      (rsp_valid),
    .rsp_pa         (rsp_pa),
    .rsp_uncacheable(rsp_uncacheable),
    .rsp_fault      (rsp_fault),
    .rsp_fast       (rsp_fast),
    .tag_va         (tag_va),
    .fc_valid       (fc_valid)
);

// File: tb/dtlb_xlate_test.sv
`timescale 1ns/1ps
module dtlb_xlate_test;
    localparam logic [39:0] BYP_MASK = 40'h0F_FFFF_FFFF;
    localparam int NE = 16;
    localparam logic [63:0] CTL_A = 64'h0000_0001_0000_0000;
    localparam logic [63:0] CTL_B = 64'h0000_0001_0000_0004;
    localparam logic [63:0] CTL_C = 64'h0000_0002_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_hpriv = 0, req_implicit = 0;
    logic [43:0] req_va = '0;
    logic [3:0]  req_size = 4'd1;
    logic [7:0]  req_asi = '0;
    logic [63:0] req_ctl = '0;
    logic wr_en = 0, inv_en = 0, wr_writable = 0, wr_side_eff = 0;
    logic [3:0]  wr_idx = '0, inv_idx = '0;
    logic [43:0] wr_va = '0;
    logic [1:0]  wr_pgsz = '0;
    logic [39:0] wr_pa = '0;
    logic [15:0] wr_ctx = '0;
    logic [7:0]  wr_part = '0;
    logic        rsp_valid, rsp_uncacheable, rsp_fast;
    logic [39:0] rsp_pa;
    logic [1:0]  rsp_fault;
    logic [43:0] tag_va;
    logic [15:0] tag_ctx;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Bench model state.
    logic [43:0] m_va [NE];
    logic [1:0]  m_sz [NE];
    logic [39:0] m_pa [NE];
    logic [15:0] m_ctx [NE];
    logic [7:0]  m_part [NE];
    bit          m_w [NE], m_se [NE], m_v [NE];
    bit          f_v;
    logic [63:0] f_ctl;
    bit   [1:0]  f_used;
    int          f_idx [2];
    logic [7:0]  f_asi [2];
    logic [43:0] t_va;
    logic [15:0] t_ctx;

    always #2 clk = ~clk;

    dtlb_xlate #(.ENTRIES(NE), .PA_IMPL_MASK(BYP_MASK)) uut (.*);

    function automatic logic [43:0] bmask(input logic [1:0] s);
        return (44'd1 << (13 + 3 * int'(s))) - 44'd1;
    endfunction

    function automatic logic [39:0] bxl(input logic [39:0] pa, input logic [1:0] s, input logic [43:0] va);
        logic [43:0] m;
        m = bmask(s);
        return (pa & ~m[39:0]) | (va[39:0] & m[39:0]);
    endfunction

    function automatic bit bnf(input logic [7:0] a);
        return a == 8'h82 || a == 8'h83 || a == 8'h8A || a == 8'h8B;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic write_ent(input int idx, input logic [43:0] va, input logic [1:0] sz, input logic [39:0] pa,
                             input logic [15:0] ctx, input logic [7:0] part, input bit w, input bit se);
        wr_en = 1; wr_idx = 4'(idx); wr_va = va; wr_pgsz = sz; wr_pa = pa;
        wr_ctx = ctx; wr_part = part; wr_writable = w; wr_side_eff = se;
        @(posedge clk); #1;
        wr_en = 0;
        m_va[idx] = va; m_sz[idx] = sz; m_pa[idx] = pa; m_ctx[idx] = ctx; m_part[idx] = part;
        m_w[idx] = w; m_se[idx] = se; m_v[idx] = 1; f_v = 0;
    endtask

    task automatic inval(input int idx);
        inv_en = 1; inv_idx = 4'(idx);
        @(posedge clk); #1;
        inv_en = 0;
        m_v[idx] = 0; f_v = 0;
    endtask

    // Predict, drive one request, then compare one cycle later.
    task automatic do_req(input logic [43:0] va, input logic [3:0] sz, input bit wr, input logic [7:0] asi,
                          input bit hp, input bit im, input logic [63:0] ctl);
        logic [39:0] e_pa;
        bit e_unc, e_fast;
        logic [1:0] e_flt;
        string tg;
        int hs, hj;
        logic [44:0] st, en, rq;
        e_pa = '0; e_unc = 0; e_fast = 0; e_flt = 2'd0; hs = -1; hj = -1;
        if (hp && im) begin
            e_pa = va[39:0] & BYP_MASK; tg = "R3";
        end else begin
            if (f_v && f_ctl == ctl) begin
                for (int s = 0; s < 2; s++) begin
                    if (hs < 0 && f_used[s] && f_asi[s] == asi) begin
                        st = {1'b0, m_va[f_idx[s]] & ~bmask(m_sz[f_idx[s]])};
                        en = st + {1'b0, bmask(m_sz[f_idx[s]])} + 45'd1;
                        rq = {1'b0, va} + 45'(sz);
                        if (st < rq && en > {1'b0, va} && (!wr || m_w[f_idx[s]])) hs = s;
                    end
                end
            end
            if (hs >= 0) begin
                hj = f_idx[hs];
                e_pa = bxl(m_pa[hj], m_sz[hj], va); e_unc = m_se[hj]; e_fast = 1;
                tg = e_unc ? "R9 R7" : "R9";
            end else begin
                for (int j = NE - 1; j >= 0; j--) begin
                    if (m_v[j] && m_ctx[j] == ctl[47:32] && m_part[j] == ctl[15:8]
                        && ((m_va[j] ^ va) & ~bmask(m_sz[j])) == '0) hj = j;
                end
                if (hj < 0) begin
                    e_flt = 2'd1; tg = "R5";
                end else if (m_se[hj] && bnf(asi)) begin
                    e_flt = 2'd2; tg = "R6";
                    t_va = va & ~44'h1FFF; t_ctx = ctl[47:32];
                end else if (wr && !m_w[hj]) begin
                    e_flt = 2'd3; tg = "R8";
                end else begin
                    e_pa = bxl(m_pa[hj], m_sz[hj], va); e_unc = m_se[hj];
                    tg = e_unc ? "R4 R7 R10" : "R4 R10";
                    if (!f_v) f_used = 2'b00;
                    f_used[1] = f_used[0]; f_idx[1] = f_idx[0]; f_asi[1] = f_asi[0];
                    f_used[0] = 1'b1; f_idx[0] = hj; f_asi[0] = asi;
                    f_v = 1; f_ctl = ctl;
                end
            end
        end
        req_valid = 1; req_va = va; req_size = sz; req_write = wr; req_asi = asi;
        req_hpriv = hp; req_implicit = im; req_ctl = ctl;
        @(posedge clk); #1;
        req_valid = 0;
        chk(rsp_valid === 1'b1, {"R2 valid ", tg}, 64'(rsp_valid), 64'd1);
        chk(rsp_fault === e_flt, {"fault ", tg}, 64'(rsp_fault), 64'(e_flt));
        chk(rsp_pa === e_pa, {"pa ", tg}, 64'(rsp_pa), 64'(e_pa));
        chk(rsp_uncacheable === e_unc, {"unc ", tg}, 64'(rsp_uncacheable), 64'(e_unc));
        chk(rsp_fast === e_fast, {"fast ", tg}, 64'(rsp_fast), 64'(e_fast));
        chk(tag_va === t_va, {"R6 tag_va ", tg}, 64'(tag_va), 64'(t_va));
        chk(tag_ctx === t_ctx, {"R6 tag_ctx ", tg}, 64'(tag_ctx), 64'(t_ctx));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int seed_val;
        int j;
        logic [43:0] va;
        logic [63:0] ctl;
        logic [7:0]  asi;
        logic [1:0]  sz;
        seed_val = int'($urandom(32'd4242));
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        f_v = 0; f_used = 2'b00; f_ctl = '0; t_va = '0; t_ctx = '0;
        f_idx[0] = 0; f_idx[1] = 0; f_asi[0] = '0; f_asi[1] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(rsp_valid === 1'b0 && rsp_fault === 2'd0 && rsp_fast === 1'b0, "R1 reset rsp", 64'(rsp_fault), 64'd0);
        chk(tag_va === '0 && tag_ctx === '0 && rsp_pa === '0, "R1 reset tag", 64'(tag_va), 64'd0);
        rst_n = 1;

        // Directed corner cases.
        write_ent(0, 44'h100000, 2'd0, 40'h12_3456_0000, 16'd1, 8'd0, 1, 0);
        write_ent(1, 44'h200000, 2'd1, 40'hA0_0000_0000, 16'd1, 8'd0, 1, 1);
        write_ent(2, 44'h400000, 2'd3, 40'h55_5540_0000, 16'd1, 8'd0, 0, 0);
        write_ent(3, 44'h100000, 2'd2, 40'h77_0000_0000, 16'd1, 8'd0, 1, 0);
        do_req(44'h100010, 4'd4, 0, 8'h80, 0, 0, CTL_A);
        chk(rsp_fast === 1'b0, "R1 first access slow", 64'(rsp_fast), 64'd0);
        do_req(44'h100010, 4'd4, 0, 8'h80, 0, 0, CTL_A);   // R9 fast repeat
        do_req(44'h101FFC, 4'd8, 1, 8'h80, 0, 0, CTL_A);   // R9 crosses page end
        do_req(44'h104000, 4'd4, 0, 8'h80, 0, 0, CTL_A);   // R4 larger overlapping page
        do_req(44'h100020, 4'd2, 0, 8'h80, 0, 0, CTL_A);   // R10 slot order
        do_req(44'h900000, 4'd4, 0, 8'h80, 0, 0, CTL_A);   // R5 miss
        do_req(44'h104000, 4'd4, 0, 8'h80, 0, 0, CTL_A);   // R5 front cache kept
        do_req(44'h200040, 4'd4, 0, 8'h82, 0, 0, CTL_A);   // R6
        do_req(44'h200040, 4'd4, 0, 8'h80, 0, 0, CTL_A);   // R7 slow
        do_req(44'h200048, 4'd4, 0, 8'h80, 0, 0, CTL_A);   // R7 fast
        do_req(44'h412345, 4'd4, 1, 8'h80, 0, 0, CTL_A);   // R8
        do_req(44'h412345, 4'd4, 0, 8'h80, 0, 0, CTL_A);
        do_req(44'h412345, 4'd4, 1, 8'h80, 0, 0, CTL_A);   // R9 write needs writable
        do_req(44'h412345, 4'd4, 0, 8'h80, 0, 0, CTL_B);   // R9 control word changed
        do_req(44'h412345, 4'd4, 0, 8'h81, 0, 0, CTL_B);   // R9 ASI tag
        do_req(44'hFFF_1234_5678, 4'd4, 0, 8'h80, 1, 1, CTL_B); // R3
        do_req(44'h412345, 4'd4, 0, 8'h81, 1, 0, CTL_B);   // R3 needs both flags
        write_ent(5, 44'h800000, 2'd0, 40'h1_0000_0000, 16'd2, 8'd0, 1, 0);
        do_req(44'h412345, 4'd4, 0, 8'h81, 0, 0, CTL_B);   // R11 flushed
        inval(0);
        do_req(44'h100010, 4'd4, 0, 8'h80, 0, 0, CTL_A);   // R11 falls to entry 3
        inval(3);
        do_req(44'h100010, 4'd4, 0, 8'h80, 0, 0, CTL_A);   // R11 miss
        @(posedge clk); #1;
        // R2: idle cycle
        chk(rsp_valid === 1'b0 && rsp_fault === 2'd0, "R2 idle", 64'(rsp_valid), 64'd0);

        // Constrained random phase.
        for (int i = 0; i < NE; i++) begin
            sz = 2'($urandom_range(0, 3));
            write_ent(i, (44'($urandom_range(0, 63)) << 18) & ~bmask(sz), sz,
                      {8'($urandom), $urandom}, ($urandom_range(0, 3) == 0) ? 16'd2 : 16'd1,
                      ($urandom_range(0, 9) == 0) ? 8'd1 : 8'd0,
                      $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
        end
        ctl = CTL_A;
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 29) == 0) begin
                j = $urandom_range(0, NE - 1);
                if ($urandom_range(0, 1) == 0) inval(j);
                else begin
                    sz = 2'($urandom_range(0, 3));
                    write_ent(j, (44'($urandom_range(0, 63)) << 18) & ~bmask(sz), sz,
                              {8'($urandom), $urandom}, 16'd1, 8'd0,
                              $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0);
                end
            end
            case ($urandom_range(0, 19))
                0: ctl = CTL_B;
                1: ctl = CTL_C;
                2: ctl = CTL_A;
                default: ;
            endcase
            case ($urandom_range(0, 3))
                0: asi = 8'h82;
                1: asi = 8'h8A;
                default: asi = 8'h80;
            endcase
            j = ($urandom_range(0, 9) < 7) ? $urandom_range(0, 3) : $urandom_range(0, NE - 1);
            if ($urandom_range(0, 9) < 8)
                va = m_va[j] | ({12'($urandom), $urandom} & bmask(m_sz[j]));
            else
                va = {12'($urandom), $urandom};
            do_req(va, 4'($urandom_range(1, 8)), $urandom_range(0, 3) == 0, asi,
                   $urandom_range(0, 19) == 0, $urandom_range(0, 1) == 0, ctl);
        end
        finish_run();
    end
endmodule